// File: doc/BRIEF.md
# Transmit Word-to-Byte Serializer with FCS Insertion

This block sits between a 32-bit frame source and a byte-wide, GMII-style transmit path. It pulls frame words through a valid/ready handshake and sends them out one byte per clock with a byte-enable and a byte-error strobe. The final word of a frame carries a modulo count, and the trailing bytes that count marks as unused are never sent.

For each frame, a flag sampled with the end-of-frame word picks one of two endings. The block can append an IEEE CRC-32 frame check sequence after the last data byte. It can also send the frame as given, because the source already placed the check sequence in the data. An error flag raised with the final word marks the rest of that frame on the byte error output.

The ready signal allows the next word to be taken while the last byte of the current one is on the wire. A frame therefore streams with no idle cycles as long as the source keeps valid high.

Top module: `tx_word_serializer`

## Requirements
- R1: Each accepted word is sent as four bytes in order: bits 31:24 first, then 23:16, then 15:8, then 7:0.
- R2: On the end-of-frame word, `in_mod` gives the count of unused trailing bytes. 0 sends all four bytes, 1 sends three, 2 sends two, and 3 sends only bits 31:24. Unused bytes never appear on `tx_d`.
- R3: When `in_crc_fwd` is 0 with the end-of-frame word, four FCS bytes follow the last data byte directly. The FCS is CRC-32 with polynomial 0x04C11DB7, seed 0xFFFFFFFF, reflected input and output, and final inversion, computed over every sent byte from the start-of-frame word onward. For the ASCII payload "123456789" the four bytes are 0x26, 0x39, 0xF4, 0xCB.
- R4: The FCS is sent least significant byte first.
- R5: When `in_crc_fwd` is 1 with the end-of-frame word, no bytes are added after the last data byte.
- R6: When `in_err` is 1 with the end-of-frame word, `tx_er` is high from the first byte of that word through the last byte of the frame, FCS included. Otherwise `tx_er` stays low for the frame.
- R7: While the source holds `in_valid` high, a frame's bytes, including its FCS, go out on consecutive cycles. `in_ready` is low during the FCS except on its last byte.
- R8: After reset, `tx_en` and `tx_er` are low and `in_ready` is high.
- R9: `tx_er` is never high while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word valid |
| in_data | input | 32 | Frame word, first byte in bits 31:24 |
| in_sop | input | 1 | Word holds the first byte of a frame |
| in_eop | input | 1 | Word holds the last byte of a frame |
| in_mod | input | 2 | Unused trailing bytes in the end-of-frame word |
| in_err | input | 1 | Frame error, sampled with the end-of-frame word |
| in_crc_fwd | input | 1 | 1 = source supplies FCS, 0 = block appends it |
| in_ready | output | 1 | Block accepts a word this cycle |
| tx_d | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit byte valid |
| tx_er | output | 1 | Transmit byte error |

## Verification
The bench sends frames of every length modulo four. A design that mis-decoded the modulo count would send a missing or extra byte, and its check sequence would also be wrong. A known CRC vector catches a wrong seed, a missing reflection, a missing inversion, or the FCS sent in the wrong byte order. Back-to-back frames catch a ready signal that stalls at a word boundary or lets a word in during the FCS, which would show as a gap or as interleaved bytes. Error frames catch a flag that starts on the wrong byte or clears before the FCS ends.

// File: rtl/tx_word_serializer.sv
module tx_word_serializer #(
  parameter logic [31:0] POLY_REFL = 32'hEDB88320,
  parameter logic [31:0] CRC_SEED  = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [1:0]  in_mod,
  input  logic        in_err,
  input  logic        in_crc_fwd,
  output logic        in_ready,
  output logic [7:0]  tx_d,
  output logic        tx_en,
  output logic        tx_er
);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    return r;
  endfunction

  logic [31:0] word_q, crc_q;
  logic [2:0]  left_q;
  logic [1:0]  fcs_cnt;
  logic        eop_q, fwd_q, err_q, first_q, fcs_q;

  wire last_data = (left_q == 3'd1);
  wire need_fcs  = eop_q && !fwd_q;
  wire take      = in_valid && in_ready;
  wire frame_end = fcs_q ? (fcs_cnt == 2'd3) : (last_data && eop_q && fwd_q);

  assign in_ready = fcs_q ? (fcs_cnt == 2'd3) : ((left_q == 3'd0) || (last_data && !need_fcs));
  assign tx_en    = fcs_q || (left_q != 3'd0);
  assign tx_er    = err_q && tx_en;
  assign tx_d     = fcs_q ? ~crc_q[7:0] : (tx_en ? word_q[31:24] : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      crc_q   <= CRC_SEED;
      left_q  <= '0;
      fcs_cnt <= '0;
      eop_q   <= 1'b0;
      fwd_q   <= 1'b0;
      err_q   <= 1'b0;
      first_q <= 1'b0;
      fcs_q   <= 1'b0;
    end else begin
      if (left_q != 3'd0) begin
        crc_q   <= crc_step(first_q ? CRC_SEED : crc_q, word_q[31:24]);
        first_q <= 1'b0;
      end else if (fcs_q) begin
        crc_q <= crc_q >> 8;
      end

      if (fcs_q) begin
        fcs_cnt <= fcs_cnt + 2'd1;
        if (fcs_cnt == 2'd3) fcs_q <= 1'b0;
      end else if (last_data && need_fcs) begin
        fcs_q   <= 1'b1;
        fcs_cnt <= 2'd0;
      end

      if (frame_end) err_q <= 1'b0;

      if (take) begin
        word_q  <= in_data;
        left_q  <= in_eop ? (3'd4 - {1'b0, in_mod}) : 3'd4;
        eop_q   <= in_eop;
        fwd_q   <= in_crc_fwd;
        err_q   <= in_eop && in_err;
        first_q <= in_sop;
      end else if (left_q != 3'd0) begin
        word_q <= word_q << 8;
        left_q <= left_q - 3'd1;
      end
    end
  end

  // R7
  fcs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_q && fcs_cnt != 2'd3) |-> !in_ready);

  // R7
  stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tx_en);

  // R3
  fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fcs_q) |=> (fcs_q && fcs_cnt == 2'd1));

  // R9
  er_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en);

  // R6
  er_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_er && !frame_end && !take) |=> tx_er);

endmodule

// File: tb/tx_word_serializer_test.sv
module tx_word_serializer_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0, in_crc_fwd = 0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_mod = '0;
  logic in_ready, tx_en, tx_er;
  logic [7:0] tx_d;

  tx_word_serializer uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_mod(in_mod), .in_err(in_err), .in_crc_fwd(in_crc_fwd),
    .in_ready(in_ready), .tx_d(tx_d), .tx_en(tx_en), .tx_er(tx_er));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, first_c = -1, last_c = -1, orphan = 0;
  bit done = 0;
  logic [7:0] got_d[$], exp_d[$];
  logic       got_e[$], exp_e[$];

  always @(negedge clk) begin
    cyc++;
    if (tx_en) begin
      got_d.push_back(tx_d); got_e.push_back(tx_er);
      if (first_c < 0) first_c = cyc;
      last_c = cyc;
    end else if (tx_er) orphan++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[k])
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ b[k][i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic send_frame(logic [7:0] pl[$], logic fwd, logic err);
    int n = pl.size();
    int nw = (n + 3) / 4;
    logic [31:0] fcs;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d = '0;
      logic last = (w == nw - 1);
      for (int b = 0; b < 4; b++)
        if (w*4 + b < n) begin
          d[31 - 8*b -: 8] = pl[w*4 + b];
          exp_d.push_back(pl[w*4 + b]);
          exp_e.push_back(last && err);
        end
      in_data = d; in_sop = (w == 0); in_eop = last;
      in_mod = last ? 2'((4 - n % 4) % 4) : 2'd0;
      in_err = err; in_crc_fwd = fwd; in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0;
    if (!fwd) begin
      fcs = ref_crc(pl);
      for (int b = 0; b < 4; b++) begin
        exp_d.push_back(fcs[8*b +: 8]);
        exp_e.push_back(err);
      end
    end
  endtask

  task automatic start();
    got_d.delete(); got_e.delete(); exp_d.delete(); exp_e.delete();
    first_c = -1; last_c = -1;
  endtask

  task automatic finish_cmp(string req_d, string req_e);
    int bad_d = 0, bad_e = 0;
    repeat (12) @(negedge clk);
    chk({req_d, " byte count"}, got_d.size(), exp_d.size());
    if (got_d.size() == exp_d.size()) begin
      foreach (exp_d[i]) begin
        if (got_d[i] !== exp_d[i] && bad_d == 0) begin
          bad_d = 1; chk({req_d, " byte value"}, got_d[i], exp_d[i]);
        end
        if (got_e[i] !== exp_e[i] && bad_e == 0) begin
          bad_e = 1; chk({req_e, " tx_er"}, got_e[i], exp_e[i]);
        end
      end
      if (!bad_d) chk({req_d, " byte value"}, 0, 0);
      if (!bad_e) chk({req_e, " tx_er"}, 0, 0);
    end
    chk("R7 contiguous bytes", last_c - first_c + 1, got_d.size());
  endtask

  task automatic t_reset();
    chk("R8 tx_en after reset", tx_en, 0);
    chk("R8 tx_er after reset", tx_er, 0);
    chk("R8 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_known_vector();
    logic [7:0] pl[$] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    start();
    send_frame(pl, 0, 0);
    repeat (12) @(negedge clk);
    chk("R3 frame length", got_d.size(), 13);
    if (got_d.size() == 13) begin
      chk("R1 first byte", got_d[0], 8'h31);
      chk("R2 last data byte mod=3", got_d[8], 8'h39);
      chk("R4 FCS byte0", got_d[9], 8'h26);
      chk("R3 FCS byte1", got_d[10], 8'h39);
      chk("R3 FCS byte2", got_d[11], 8'hF4);
      chk("R4 FCS byte3", got_d[12], 8'hCB);
    end
  endtask

  task automatic t_mod_sweep();
    for (int len = 13; len <= 16; len++) begin
      logic [7:0] pl[$];
      start();
      for (int i = 0; i < len; i++) pl.push_back(8'(i*37 + len));
      send_frame(pl, 0, 0);
      finish_cmp("R2 R3", "R6");
    end
  endtask

  task automatic t_fwd();
    logic [7:0] pl[$];
    start();
    for (int i = 0; i < 10; i++) pl.push_back(8'(8'hA0 + i));
    send_frame(pl, 1, 0);
    finish_cmp("R5 no FCS", "R6");
  endtask

  task automatic t_error();
    logic [7:0] pl[$];
    start();
    for (int i = 0; i < 11; i++) pl.push_back(8'(i*3));
    send_frame(pl, 0, 1);
    finish_cmp("R3", "R6 error span");
    start();
    send_frame(pl, 1, 1);
    finish_cmp("R5", "R6 error span no FCS");
  endtask

  task automatic t_back_to_back();
    logic [7:0] a[$], b[$], c[$];
    start();
    for (int i = 0; i < 7; i++) a.push_back(8'(i + 8'h40));
    for (int i = 0; i < 8; i++) b.push_back(8'(i + 8'h80));
    for (int i = 0; i < 5; i++) c.push_back(8'(i + 8'hC0));
    send_frame(a, 0, 0);
    send_frame(b, 1, 1);
    send_frame(c, 0, 0);
    finish_cmp("R7 back-to-back", "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_known_vector();
    t_mod_sweep();
    t_fwd();
    t_error();
    t_back_to_back();
    chk("R9 tx_er without tx_en", orphan, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule